// File: doc/BRIEF.md
# Right-Justified Serial PCM Word Receiver

This block takes a mono stream of oversampled PCM samples arriving on three wires (a serial data line, a bit clock and a word clock) and turns each frame into one parallel signed word. All logic runs on the rising edge of the bit clock. The data line is sampled into a shift register on every rising bit clock edge. A transition of the word clock marks the end of a frame. When it arrives, the most recent `WORD_W` bits are copied into an output register, and a one-cycle valid pulse marks the new word.

The format is right-justified. The least significant bit is the last bit sampled before the word clock changes, and the most significant bit arrives first. A frame may therefore carry any number of leading filler bits, and the data can sit anywhere in a longer word period provided it ends at the word clock transition. If a frame carries fewer bits than a word needs, the block still delivers the word: the missing upper bits read as zero and a short-frame flag is raised alongside it. A parameter chooses which word clock transitions end a frame: both, rising only, or falling only.

Top module: `pcm_rj_receiver`

## Requirements
- R1: While `rst_n` is low, `word` is 0 and `word_valid` and `short_frame` are 0.
- R2: A delivered `word` holds the last `WORD_W` bits sampled on rising `bclk` edges before the frame boundary, with the first-sampled of those bits in bit `WORD_W-1` (the sign bit of a two's complement value) and the last-sampled bit in bit 0.
- R3: A frame boundary is seen at a rising `bclk` edge when the `wclk` level sampled there differs from the level sampled at the previous rising edge. The data bit sampled at that same edge is the first bit of the next frame.
- R4: `word_valid` is 1 for exactly the one cycle after the `bclk` edge that sees a boundary. `word` and `short_frame` change only in that cycle and hold their values otherwise.
- R5: Any bits sampled before the last `WORD_W` bits of a frame are discarded, so leading filler of any length does not affect the word.
- R6: If fewer than `WORD_W` bits were sampled since the previous boundary (or since reset), `short_frame` is 1 with the word. The bits that were received are right-aligned and every missing upper bit reads 0.
- R7: `WEDGE` selects the boundary transitions: `WEDGE_ANY` (0) uses both, `WEDGE_RISE` (1) uses low-to-high only, `WEDGE_FALL` (2) uses high-to-low only. An unselected transition produces no `word_valid`, leaves `word` unchanged, and does not discard bits already accumulated.
- R8: The first rising `bclk` edge after reset is released never reports a boundary, whatever the `wclk` level.
- R9: A frame of exactly `WORD_W` bits, or more, gives `short_frame` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdata | input | 1 | Serial data, MSB first, right-justified to the frame end |
| wclk | input | 1 | Word clock; selected transitions end a frame |
| word | output | WORD_W | Last received word, signed two's complement |
| word_valid | output | 1 | One-cycle pulse when a new word is presented |
| short_frame | output | 1 | Set with a word whose frame was shorter than WORD_W bits |

## Verification
The bench builds two copies of the block that share all inputs. The first uses the default 24-bit word with both word clock transitions active. The second uses an 8-bit word with rising transitions only. The narrow copy regularly sees frames far longer than its width, which exercises discard of leading bits. It also sees every falling transition ignored while its bits keep accumulating. The wide copy covers exact-length, one-bit-short and one-bit frames, and frames with a negative sign bit.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    // Which word clock transitions close a frame
    typedef enum logic [1:0] {
        WEDGE_ANY  = 2'd0,
        WEDGE_RISE = 2'd1,
        WEDGE_FALL = 2'd2
    } wedge_e;

    // Word clock tracking state
    typedef struct packed {
        logic prev;
        logic primed;
    } wedge_st_t;

endpackage

// File: rtl/pcm_rx_wedge.sv
module pcm_rx_wedge
    import pcm_rx_pkg::*;
#(
    parameter wedge_e WEDGE = WEDGE_ANY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wclk,
    output logic frame_end
);

    wedge_st_t st_d, st_q;
    logic      hit;

    // Transition qualifier chosen by parameter
    generate
        if (WEDGE == WEDGE_RISE) begin : g_rise
            assign hit = wclk & ~st_q.prev;
        end else if (WEDGE == WEDGE_FALL) begin : g_fall
            assign hit = ~wclk & st_q.prev;
        end else begin : g_any
            assign hit = wclk ^ st_q.prev;
        end
    endgenerate

    // No boundary until one real sample of wclk has been taken
    assign frame_end = st_q.primed & hit;

    always_comb begin
        st_d        = st_q;
        st_d.prev   = wclk;
        st_d.primed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata,
    input  logic              frame_end,
    output logic [WORD_W-1:0] acc_word,
    output logic              acc_short
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] bits;
        logic [CNT_W-1:0]  cnt;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_end) begin
            // Bit at the boundary edge opens the next frame; older bits drop
            st_d.bits = {{(WORD_W-1){1'b0}}, sdata};
            st_d.cnt  = CNT_W'(1);
        end else begin
            st_d.bits = {st_q.bits[WORD_W-2:0], sdata};
            st_d.cnt  = (st_q.cnt == CNT_FULL) ? st_q.cnt : st_q.cnt + CNT_W'(1);
        end
    end

    assign acc_word  = st_q.bits;
    assign acc_short = (st_q.cnt < CNT_FULL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pcm_rx_hold.sv
module pcm_rx_hold #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end,
    input  logic [WORD_W-1:0] acc_word,
    input  logic              acc_short,
    output logic [WORD_W-1:0] out_word,
    output logic              out_valid,
    output logic              out_short
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              valid;
        logic              short_f;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = frame_end;
        if (frame_end) begin
            st_d.word    = acc_word;
            st_d.short_f = acc_short;
        end
    end

    assign out_word  = st_q.word;
    assign out_valid = st_q.valid;
    assign out_short = st_q.short_f;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pcm_rj_receiver.sv
module pcm_rj_receiver
    import pcm_rx_pkg::*;
#(
    parameter int     WORD_W = 24,
    parameter wedge_e WEDGE  = WEDGE_ANY
) (
    input  logic                     bclk,
    input  logic                     rst_n,
    input  logic                     sdata,
    input  logic                     wclk,
    output logic signed [WORD_W-1:0] word,
    output logic                     word_valid,
    output logic                     short_frame
);

    logic              frame_end;
    logic [WORD_W-1:0] acc_word;
    logic              acc_short;
    logic [WORD_W-1:0] held_word;

    pcm_rx_wedge #(
        .WEDGE (WEDGE)
    ) u_wedge (
        .clk       (bclk),
        .rst_n     (rst_n),
        .wclk      (wclk),
        .frame_end (frame_end)
    );

    pcm_rx_shift #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk       (bclk),
        .rst_n     (rst_n),
        .sdata     (sdata),
        .frame_end (frame_end),
        .acc_word  (acc_word),
        .acc_short (acc_short)
    );

    pcm_rx_hold #(
        .WORD_W (WORD_W)
    ) u_hold (
        .clk       (bclk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .acc_word  (acc_word),
        .acc_short (acc_short),
        .out_word  (held_word),
        .out_valid (word_valid),
        .out_short (short_frame)
    );

    assign word = $signed(held_word);

endmodule

// File: rtl/pcm_rj_receiver_chk.sv
module pcm_rj_receiver_chk
    import pcm_rx_pkg::*;
#(
    parameter int     WORD_W = 24,
    parameter wedge_e WEDGE  = WEDGE_ANY
) (
    input logic              bclk,
    input logic              rst_n,
    input logic              wclk,
    input logic [WORD_W-1:0] word,
    input logic              word_valid,
    input logic              short_frame
);

    // R1
    reset_clear_chk: assert property (@(posedge bclk)
        !rst_n |-> (word == '0 && !word_valid && !short_frame));

    // R4
    word_hold_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        !word_valid |-> $stable(word));

    // R4
    short_hold_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        !word_valid |-> $stable(short_frame));

    // R3
    valid_needs_change_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        word_valid |-> ($past(wclk) != $past(wclk, 2)));

    // R3
    quiet_no_valid_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        ($past(wclk) == $past(wclk, 2)) |-> !word_valid);

    generate
        if (WEDGE == WEDGE_RISE) begin : g_rise_chk
            // R7
            rise_only_chk: assert property (@(posedge bclk) disable iff (!rst_n)
                word_valid |-> ($past(wclk) && !$past(wclk, 2)));
        end else if (WEDGE == WEDGE_FALL) begin : g_fall_chk
            // R7
            fall_only_chk: assert property (@(posedge bclk) disable iff (!rst_n)
                word_valid |-> (!$past(wclk) && $past(wclk, 2)));
        end
    endgenerate

endmodule

bind pcm_rj_receiver pcm_rj_receiver_chk #(
    .WORD_W (WORD_W),
    .WEDGE  (WEDGE)
) u_chk (
    .bclk        (bclk),
    .rst_n       (rst_n),
    .wclk        (wclk),
    .word        (word),
    .word_valid  (word_valid),
    .short_frame (short_frame)
);

// File: tb/pcm_rj_receiver_bench.sv
module pcm_rx_model #(
    parameter int W    = 24,
    parameter int MODE = 0
) (
    input  logic         bclk,
    input  logic         rst_n,
    input  logic         sdata,
    input  logic         wclk,
    output logic [W-1:0] ew,
    output logic         ev,
    output logic         es
);
    bit q[$];
    bit prev;
    bit primed;

    always @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete();
            prev = 0; primed = 0;
            ew = '0; ev = 0; es = 0;
        end else begin
            bit hit;
            if (MODE == 1)      hit = primed && wclk && !prev;
            else if (MODE == 2) hit = primed && !wclk && prev;
            else                hit = primed && (wclk != prev);
            ev = hit;
            if (hit) begin
                es = (q.size() < W);
                ew = '0;
                foreach (q[i]) ew = {ew[W-2:0], q[i]};
                q.delete();
            end
            q.push_back(sdata);
            if (q.size() > W) void'(q.pop_front());
            prev = wclk;
            primed = 1;
        end
    end
endmodule

module pcm_rj_receiver_bench;
    import pcm_rx_pkg::*;

    logic bclk = 1'b0;
    logic rst_n, sdata, wclk;
    logic [23:0] wa;
    logic        va, sa;
    logic [7:0]  wb;
    logic        vb, sb;
    logic [23:0] ewa;
    logic        eva, esa;
    logic [7:0]  ewb;
    logic        evb, esb;
    int checks = 0;
    int failures = 0;

    always #10 bclk = ~bclk;

    pcm_rj_receiver u_pcm_rj_receiver (
        .bclk(bclk), .rst_n(rst_n), .sdata(sdata), .wclk(wclk),
        .word(wa), .word_valid(va), .short_frame(sa));

    pcm_rj_receiver #(.WORD_W(8), .WEDGE(WEDGE_RISE)) u_pcm_rj_receiver_rise (
        .bclk(bclk), .rst_n(rst_n), .sdata(sdata), .wclk(wclk),
        .word(wb), .word_valid(vb), .short_frame(sb));

    pcm_rx_model #(.W(24), .MODE(0)) u_model_a (
        .bclk(bclk), .rst_n(rst_n), .sdata(sdata), .wclk(wclk),
        .ew(ewa), .ev(eva), .es(esa));

    pcm_rx_model #(.W(8), .MODE(1)) u_model_b (
        .bclk(bclk), .rst_n(rst_n), .sdata(sdata), .wclk(wclk),
        .ew(ewb), .ev(evb), .es(esb));

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the behavioural models
    always @(negedge bclk) begin
        chk("R2", "A word", 64'(wa), 64'(ewa));
        chk("R4", "A valid", 64'(va), 64'(eva));
        chk("R6", "A short", 64'(sa), 64'(esa));
        chk("R2", "B word", 64'(wb), 64'(ewb));
        chk("R4", "B valid", 64'(vb), 64'(evb));
        chk("R6", "B short", 64'(sb), 64'(esb));
    end

    // Called at a negedge: drive bits MSB first, one per bit clock
    task automatic send_bits(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdata = v[i];
            @(negedge bclk);
        end
    endtask

    // Toggle word clock with the first bit of the next frame
    task automatic close_frame(input logic b);
        wclk  = ~wclk;
        sdata = b;
        @(negedge bclk);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wclk = 1'b1; sdata = 1'b0;
        repeat (3) @(negedge bclk);
        chk("R1", "A word in reset", 64'(wa), 64'd0);
        chk("R1", "A valid in reset", 64'(va), 64'd0);
        chk("R1", "B short in reset", 64'(sb), 64'd0);
        rst_n = 1'b1;
        @(negedge bclk);
        chk("R8", "A valid first edge", 64'(va), 64'd0);
        chk("R8", "B valid first edge", 64'(vb), 64'd0);

        close_frame(1'b0);                         // falling
        chk("R3", "A valid on fall", 64'(va), 64'd1);
        chk("R6", "A short after reset", 64'(sa), 64'd1);
        chk("R7", "B ignores fall", 64'(vb), 64'd0);

        send_bits(64'h8F0A53, 24);
        close_frame(1'b0);                         // rising
        chk("R2", "A word V1", 64'(wa), 64'h8F0A53);
        checks++;
        if (!($signed(wa) < 0)) begin
            failures++;
            $display("FAIL R2 A sign actual=%0d expected=negative", $signed(wa));
        end
        chk("R9", "A short V1", 64'(sa), 64'd0);
        chk("R5", "B low byte V1", 64'(wb), 64'h53);
        chk("R7", "B valid on rise", 64'(vb), 64'd1);

        send_bits(64'h7F, 7);
        send_bits(64'h123456, 24);
        close_frame(1'b1);                         // falling
        chk("R5", "A word after filler", 64'(wa), 64'h123456);
        chk("R7", "B no valid on fall", 64'(vb), 64'd0);
        chk("R7", "B word held", 64'(wb), 64'h53);

        send_bits(64'h2B5, 10);
        close_frame(1'b0);                         // rising
        chk("R6", "A short word", 64'(wa), 64'h0006B5);
        chk("R6", "A short flag", 64'(sa), 64'd1);
        chk("R7", "B kept bits across fall", 64'(wb), 64'hB5);

        send_bits(64'h7A5C3E, 23);
        close_frame(1'b1);                         // falling
        chk("R9", "A exact word", 64'(wa), 64'h7A5C3E);
        chk("R9", "A exact not short", 64'(sa), 64'd0);

        send_bits(64'h0, 22);
        close_frame(1'b0);                         // rising
        chk("R9", "A one short word", 64'(wa), 64'h400000);
        chk("R9", "A one short flag", 64'(sa), 64'd1);

        close_frame(1'b1);                         // falling
        close_frame(1'b0);                         // rising
        chk("R3", "A one-bit frame", 64'(wa), 64'h1);
        chk("R6", "A one-bit short", 64'(sa), 64'd1);
        chk("R2", "B word", 64'(wb), 64'h01);

        for (int f = 0; f < 60; f++) begin
            int lead = $urandom_range(0, 6);
            int n    = $urandom_range(1, 30);
            send_bits({$urandom, $urandom}, lead + n);
            close_frame(1'($urandom_range(0, 1)));
        end
        repeat (4) @(negedge bclk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule